// File: doc/BRIEF.md
# Section Translation Lookaside Buffer

This block is a small fully associative store of section translation descriptors. It sits between the requester and a page table walker. Every translation request carries a modified virtual address. Its upper twelve bits, the section index, are compared with all stored tags in parallel. On a match the stored descriptor comes back in the same cycle, ready for address translation and the permission check.

On a mismatch the block asks the walker for the descriptor of that section and waits for the answer. It returns the fetched descriptor to the requester and keeps it for later use, but only if the descriptor is a section descriptor. Page table maintenance uses two invalidate inputs. One clears every entry. The other clears only the entry whose section covers a given address.

The control path is a two-state machine. `ST_LOOKUP` searches the store. It stays put on an idle cycle or a hit, and takes the transition *miss* to `ST_WALK` when a valid request finds no entry. `ST_WALK` holds the walk request until the walker acknowledges. It then takes the transition *walk done* back to `ST_LOOKUP`, completing the request in the acknowledge cycle.

Top module: `sect_tlb`

## Requirements
- R1: After reset no entry is valid, `walk_req` and `rsp_valid` are low, and the first request to any section misses.
- R2: A request that misses in `ST_LOOKUP` holds `req_ready` low. From the next cycle until `walk_ack`, `walk_req` is high and `walk_idx` carries the request's address bits [31:20], unchanged.
- R3: In the cycle `walk_ack` is high, `rsp_valid` and `req_ready` are high, `rsp_hit` is low and `rsp_desc` equals `walk_desc`.
- R4: A request whose bits [31:20] match a valid entry completes in the cycle it is presented, with `rsp_valid`, `req_ready` and `rsp_hit` high, `rsp_desc` equal to the stored descriptor, and no walk. Address bits [19:0] play no part in the match.
- R5: A fetched descriptor is installed only when its bits [1:0] equal 2'b10. Any other code is returned to the requester but not stored, so the next request to that section walks again.
- R6: `inv_all` clears every entry at the next clock edge. It also returns the replacement pointer to slot 0.
- R7: `inv_one` clears only the entry whose tag equals `inv_mva[31:20]`. All other entries keep hitting.
- R8: When an invalidate arrives in the same cycle as a fill, the invalidate wins. `inv_all`, or `inv_one` with the fill's tag, drops the fill.
- R9: Eight entries are replaced round-robin. The pointer starts at slot 0 and advances by one per installed fill, so the ninth distinct section installed after `inv_all` evicts the first one and leaves the other seven.
- R10: `rsp_valid` is never high without `req_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request present; held until `req_ready` |
| req_mva | input | 32 | Modified virtual address of the request |
| req_ready | output | 1 | Request completes this cycle |
| rsp_valid | output | 1 | Descriptor on `rsp_desc` is valid |
| rsp_hit | output | 1 | Response came from a stored entry |
| rsp_desc | output | 32 | Descriptor for translation and permission check |
| walk_req | output | 1 | Walker fetch request |
| walk_idx | output | 12 | Section index to fetch |
| walk_ack | input | 1 | Walker returns a descriptor this cycle |
| walk_desc | input | 32 | Descriptor from the walker |
| inv_all | input | 1 | Invalidate every entry |
| inv_one | input | 1 | Invalidate the entry covering `inv_mva` |
| inv_mva | input | 32 | Address for invalidate-by-address |

## Verification
A hit is due combinationally in the cycle the request is presented. The bench drives the request after a falling edge and samples 1 ns later, before the next rising edge. After a miss, `walk_req` appears one rising edge after the request, and the bench samples it after the following falling edge. The fill response is combinational in the acknowledge cycle, and the filled entry first hits on a request presented after the next rising edge. Invalidates take effect at the rising edge that follows their falling-edge drive, so every follow-up lookup is placed at least one edge later.

// File: rtl/sect_tlb_pkg.sv
package sect_tlb_pkg;
    typedef enum logic [0:0] {
        ST_LOOKUP = 1'b0,
        ST_WALK   = 1'b1
    } tlb_state_e;

    localparam logic [1:0] SECTION_CODE = 2'b10;
endpackage

// File: rtl/tlb_rr_ptr.sv
module tlb_rr_ptr #(
    parameter int ENTRIES = 8,
    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             advance,
    output logic [IDX_W-1:0] ptr
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            ptr <= '0;
        end else if (advance) begin
            ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
        end
    end
endmodule

// File: rtl/tlb_store.sv
module tlb_store #(
    parameter int ENTRIES = 8,
    parameter int TAG_W   = 12,
    parameter int DESC_W  = 32,
    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TAG_W-1:0]  lk_tag,
    output logic              lk_hit,
    output logic [DESC_W-1:0] lk_desc,
    input  logic              fill_en,
    input  logic [TAG_W-1:0]  fill_tag,
    input  logic [DESC_W-1:0] fill_desc,
    input  logic              inv_all,
    input  logic              inv_one,
    input  logic [TAG_W-1:0]  inv_tag
);
    logic [ENTRIES-1:0] valid_q;
    logic [TAG_W-1:0]   tag_q  [ENTRIES];
    logic [DESC_W-1:0]  desc_q [ENTRIES];
    logic [ENTRIES-1:0] hit_vec;
    logic [ENTRIES-1:0] kill_vec;
    logic [IDX_W-1:0]   ptr;
    logic               do_fill;

    // invalidate beats fill
    assign do_fill = fill_en && !inv_all && !(inv_one && (inv_tag == fill_tag));

    tlb_rr_ptr #(.ENTRIES(ENTRIES)) u_ptr (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (inv_all),
        .advance (do_fill),
        .ptr     (ptr)
    );

    for (genvar g = 0; g < ENTRIES; g++) begin : g_match
        assign hit_vec[g]  = valid_q[g] && (tag_q[g] == lk_tag);
        assign kill_vec[g] = inv_one && valid_q[g] && (tag_q[g] == inv_tag);
    end

    assign lk_hit = |hit_vec;

    always_comb begin
        lk_desc = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (hit_vec[i]) lk_desc = lk_desc | desc_q[i];
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < ENTRIES; i++) begin
            if (!rst_n || inv_all) begin
                valid_q[i] <= 1'b0;
            end else if (do_fill && (ptr == IDX_W'(i))) begin
                valid_q[i] <= 1'b1;
                tag_q[i]   <= fill_tag;
                desc_q[i]  <= fill_desc;
            end else if (kill_vec[i]) begin
                valid_q[i] <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/tlb_ctrl.sv
module tlb_ctrl
    import sect_tlb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    input  logic lk_hit,
    input  logic walk_ack,
    output logic capture,
    output logic req_ready,
    output logic rsp_valid,
    output logic rsp_hit,
    output logic walk_req,
    output logic walk_done
);
    tlb_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_LOOKUP;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d   = state_q;
        capture   = 1'b0;
        req_ready = 1'b0;
        rsp_valid = 1'b0;
        rsp_hit   = 1'b0;
        walk_req  = 1'b0;
        walk_done = 1'b0;
        unique case (state_q)
            ST_LOOKUP: begin
                if (req_valid && lk_hit) begin
                    req_ready = 1'b1;
                    rsp_valid = 1'b1;
                    rsp_hit   = 1'b1;
                end else if (req_valid) begin
                    capture = 1'b1;
                    state_d = ST_WALK;
                end
            end
            ST_WALK: begin
                walk_req = 1'b1;
                if (walk_ack) begin
                    req_ready = 1'b1;
                    rsp_valid = 1'b1;
                    walk_done = 1'b1;
                    state_d   = ST_LOOKUP;
                end
            end
            default: state_d = ST_LOOKUP;
        endcase
    end
endmodule

// File: rtl/sect_tlb.sv
module sect_tlb #(
    parameter int ADDR_W  = 32,
    parameter int TAG_W   = 12,
    parameter int DESC_W  = 32,
    parameter int ENTRIES = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_mva,
    output logic              req_ready,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [DESC_W-1:0] rsp_desc,
    output logic              walk_req,
    output logic [TAG_W-1:0]  walk_idx,
    input  logic              walk_ack,
    input  logic [DESC_W-1:0] walk_desc,
    input  logic              inv_all,
    input  logic              inv_one,
    input  logic [ADDR_W-1:0] inv_mva
);
    import sect_tlb_pkg::*;

    logic              lk_hit;
    logic [DESC_W-1:0] lk_desc;
    logic              capture;
    logic              walk_done;
    logic              fill_en;
    logic [TAG_W-1:0]  tag_q;

    always_ff @(posedge clk) begin
        if (!rst_n)       tag_q <= '0;
        else if (capture) tag_q <= req_mva[ADDR_W-1 -: TAG_W];
    end

    assign walk_idx = tag_q;
    assign fill_en  = walk_done && (walk_desc[1:0] == SECTION_CODE);
    assign rsp_desc = walk_done ? walk_desc : lk_desc;

    tlb_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .lk_hit    (lk_hit),
        .walk_ack  (walk_ack),
        .capture   (capture),
        .req_ready (req_ready),
        .rsp_valid (rsp_valid),
        .rsp_hit   (rsp_hit),
        .walk_req  (walk_req),
        .walk_done (walk_done)
    );

    tlb_store #(
        .ENTRIES (ENTRIES),
        .TAG_W   (TAG_W),
        .DESC_W  (DESC_W)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .lk_tag    (req_mva[ADDR_W-1 -: TAG_W]),
        .lk_hit    (lk_hit),
        .lk_desc   (lk_desc),
        .fill_en   (fill_en),
        .fill_tag  (tag_q),
        .fill_desc (walk_desc),
        .inv_all   (inv_all),
        .inv_one   (inv_one),
        .inv_tag   (inv_mva[ADDR_W-1 -: TAG_W])
    );
endmodule

// File: rtl/sect_tlb_chk.sv
module sect_tlb_chk #(
    parameter int ADDR_W = 32,
    parameter int TAG_W  = 12,
    parameter int DESC_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [ADDR_W-1:0] req_mva,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic              rsp_hit,
    input logic [DESC_W-1:0] rsp_desc,
    input logic              walk_req,
    input logic [TAG_W-1:0]  walk_idx,
    input logic              walk_ack,
    input logic [DESC_W-1:0] walk_desc,
    input logic              inv_all,
    input logic              inv_one,
    input logic [ADDR_W-1:0] inv_mva
);
    // R2
    miss_starts_walk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready && !walk_req) |=> walk_req);

    // R2
    walk_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (walk_req && !walk_ack) |=> (walk_req && $stable(walk_idx)));

    // R3
    walk_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (walk_req && walk_ack) |-> (rsp_valid && req_ready && !rsp_hit && rsp_desc == walk_desc));

    // R4
    hit_no_walk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_hit |-> (rsp_valid && req_ready && !walk_req));

    // R6
    flush_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inv_all |=> !rsp_hit);

    // R10
    rsp_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> req_valid);
endmodule

bind sect_tlb sect_tlb_chk u_chk (.*);

// File: tb/tb_sect_tlb.sv
module tb_sect_tlb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid;
    logic [31:0] req_mva;
    logic        req_ready;
    logic        rsp_valid;
    logic        rsp_hit;
    logic [31:0] rsp_desc;
    logic        walk_req;
    logic [11:0] walk_idx;
    logic        walk_ack;
    logic [31:0] walk_desc;
    logic        inv_all;
    logic        inv_one;
    logic [31:0] inv_mva;

    int n_chk  = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    sect_tlb dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_mva   (req_mva),
        .req_ready (req_ready),
        .rsp_valid (rsp_valid),
        .rsp_hit   (rsp_hit),
        .rsp_desc  (rsp_desc),
        .walk_req  (walk_req),
        .walk_idx  (walk_idx),
        .walk_ack  (walk_ack),
        .walk_desc (walk_desc),
        .inv_all   (inv_all),
        .inv_one   (inv_one),
        .inv_mva   (inv_mva)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] sec(input logic [11:0] s);
        return {s ^ 12'h5A5, 20'h00C12};
    endfunction

    // One request; on a miss the stub walker answers with d after two wait cycles.
    task automatic access(input logic [31:0] mva, input bit exp_hit, input logic [31:0] d,
                          input bit inv_same, input string tag);
        @(negedge clk);
        req_valid = 1'b1;
        req_mva   = mva;
        #1;
        if (exp_hit) begin
            chk(rsp_valid && rsp_hit && req_ready, {tag, " hit"}, {31'b0, rsp_hit}, 32'd1);
            chk(rsp_desc == d, {tag, " hit desc"}, rsp_desc, d);
            chk(!walk_req, {tag, " no walk on hit"}, {31'b0, walk_req}, 32'd0);
        end else begin
            chk(!req_ready && !rsp_hit, {tag, " miss holds ready low"}, {31'b0, req_ready}, 32'd0);
            @(negedge clk); #1;
            chk(walk_req && walk_idx == mva[31:20], {tag, " R2 walk idx"}, {20'b0, walk_idx}, {20'b0, mva[31:20]});
            @(negedge clk); #1;
            chk(walk_req && !req_ready && walk_idx == mva[31:20], {tag, " R2 walk held"},
                {31'b0, walk_req}, 32'd1);
            walk_ack  = 1'b1;
            walk_desc = d;
            if (inv_same) begin
                inv_one = 1'b1;
                inv_mva = mva;
            end
            #1;
            chk(rsp_valid && req_ready && !rsp_hit, {tag, " R3 walk completes"}, {31'b0, rsp_valid}, 32'd1);
            chk(rsp_desc == d, {tag, " R3 walk desc"}, rsp_desc, d);
        end
        @(negedge clk);
        req_valid = 1'b0;
        walk_ack  = 1'b0;
        inv_one   = 1'b0;
    endtask

    task automatic inval(input bit all, input logic [31:0] mva);
        @(negedge clk);
        if (all) inv_all = 1'b1;
        else begin
            inv_one = 1'b1;
            inv_mva = mva;
        end
        @(negedge clk);
        inv_all = 1'b0;
        inv_one = 1'b0;
    endtask

    task automatic t_reset();
        @(negedge clk); #1;
        chk(!walk_req && !rsp_valid, "R1 reset outputs", {30'b0, walk_req, rsp_valid}, 32'd0);
        access(32'h0000_0000, 1'b0, sec(12'h000), 1'b0, "R1 first access");
    endtask

    task automatic t_fill_hit();
        access(32'hB000_4000, 1'b0, sec(12'hB00), 1'b0, "R4 fill");
        access(32'hB00F_FFFC, 1'b1, sec(12'hB00), 1'b0, "R4 other offset");
        @(negedge clk); #1;
        chk(!rsp_valid, "R10 idle no response", {31'b0, rsp_valid}, 32'd0);
    endtask

    task automatic t_nonsection();
        access(32'h4420_0000, 1'b0, 32'h1234_5671, 1'b0, "R5 coarse code");
        access(32'h4420_0010, 1'b0, 32'h1234_5672, 1'b0, "R5 walks again");
        access(32'h4420_0020, 1'b1, 32'h1234_5672, 1'b0, "R5 section stored");
    endtask

    task automatic t_inv_one();
        access(32'hA000_0010, 1'b0, sec(12'hA00), 1'b0, "R7 fill a");
        access(32'hA010_0000, 1'b0, sec(12'hA01), 1'b0, "R7 fill b");
        inval(1'b0, 32'hA000_0054);
        access(32'hA010_0004, 1'b1, sec(12'hA01), 1'b0, "R7 neighbour kept");
        access(32'hA000_0010, 1'b0, sec(12'hA00), 1'b0, "R7 target cleared");
    endtask

    task automatic t_inv_all();
        inval(1'b1, 32'h0);
        access(32'hA010_0000, 1'b0, sec(12'hA01), 1'b0, "R6 flush b");
        access(32'hB000_0000, 1'b0, sec(12'hB00), 1'b0, "R6 flush c");
    endtask

    task automatic t_collide();
        access(32'h7770_0000, 1'b0, sec(12'h777), 1'b1, "R8 inval with fill");
        access(32'h7770_0000, 1'b0, sec(12'h777), 1'b0, "R8 fill dropped");
        access(32'h7770_0100, 1'b1, sec(12'h777), 1'b0, "R8 later fill kept");
    endtask

    task automatic t_round_robin();
        inval(1'b1, 32'h0);
        for (int i = 0; i < 9; i++) begin
            access({12'h200 + 12'(i), 20'h0}, 1'b0, sec(12'h200 + 12'(i)), 1'b0, "R9 fill");
        end
        for (int i = 1; i < 9; i++) begin
            access({12'h200 + 12'(i), 20'h8}, 1'b1, sec(12'h200 + 12'(i)), 1'b0, "R9 retained");
        end
        access(32'h2000_0000, 1'b0, sec(12'h200), 1'b0, "R9 oldest evicted");
    endtask

    initial begin
        rst_n = 1'b0; req_valid = 1'b0; req_mva = '0; walk_ack = 1'b0; walk_desc = '0;
        inv_all = 1'b0; inv_one = 1'b0; inv_mva = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_fill_hit();
        t_nonsection();
        t_inv_one();
        t_inv_all();
        t_collide();
        t_round_robin();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(8 * 100000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule